// File: doc/BRIEF.md
# Pointer Adder with Flags

This unit does the 16-bit address arithmetic of a small processor core. There are three operations. The first adds a register pair to the accumulator pair. The second adds a signed 8-bit displacement to the stack pointer and sends the sum back to the stack pointer. The third forms the same displacement sum but sends it to the accumulator pair, so the stack pointer keeps its value. The sequencer supplies an operation code, a base value (the accumulator pair or the stack pointer), a second pair, a displacement byte and the current zero flag, and pulses a start strobe.

The unit takes a copy of its operands when it accepts a start. It then counts the fixed clock budget of the chosen operation. When the count ends it registers the 16-bit result, a destination select and the new flag byte, and it raises a one-cycle done strobe. These outputs keep their values until the next operation completes. The flag byte uses the accumulator ALU layout: zero in bit 7, subtract in bit 6, half-carry in bit 5, carry in bit 4. Bits 3 to 0 are always zero.

Top module: `ptr_add_unit`

## Requirements
- R1: Operation code 0 (pair add) gives result = (base + addend) mod 2^16 with dest_sp = 0.
- R2: For pair add, flag bit 5 is the carry out of bit 11 and flag bit 4 is the carry out of bit 15. Bit 6 is 0. Bit 7 equals z_in as sampled with the accepted start.
- R3: For operation codes 1 and 2, the displacement is sign-extended from 8 bits, and the result is (base + extended displacement) mod 2^16.
- R4: Operation code 1 (stack update) drives dest_sp = 1. Operation code 2 (stack load) drives dest_sp = 0.
- R5: For operation codes 1 and 2, flag bits 7 and 6 are 0. Flag bit 5 is the carry out of bit 3 and flag bit 4 is the carry out of bit 7 of the base plus the displacement byte (equivalently, bits 4 and 8 of base XOR extended displacement XOR result).
- R6: done is a single-cycle pulse. It is high in the cycle after the clock edge that comes 8 (code 0), 16 (code 1) or 12 (code 2) edges after the edge that accepted start.
- R7: A start that arrives while an operation is in progress is ignored. It changes neither the operation in progress nor its operands.
- R8: result, flags_out and dest_sp change only in a cycle where done is high, and otherwise hold their values.
- R9: flags_out[3:0] is always 0.
- R10: A start with operation code 3 is ignored: no done follows and the outputs do not change.
- R11: While rst is high, result, flags_out, dest_sp and done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation; sampled when idle |
| op | input | 2 | 0 pair add, 1 stack update, 2 stack load, 3 reserved |
| base | input | 16 | Accumulator pair for code 0, stack pointer for codes 1 and 2 |
| addend | input | 16 | Second register pair for code 0 |
| disp | input | 8 | Signed displacement for codes 1 and 2 |
| z_in | input | 1 | Incoming zero flag, kept by pair add |
| result | output | 16 | Registered 16-bit sum |
| dest_sp | output | 1 | 1: write result to stack pointer; 0: to accumulator pair |
| flags_out | output | 8 | Z N H C in bits 7..4, low nibble zero |
| done | output | 1 | One-cycle completion strobe |

## Verification
The latency property assumes that the checker's own record of accepted starts matches the unit's. This holds only if start, op and the operands are steady around the sampling edge, and only if a start that coincides with a done pulse counts as accepted. The bench changes inputs only on falling edges, and its reference model accepts a start on the done cycle in the same way. The stimulus includes starts during busy periods and starts with the reserved code. These cannot break any property, because the checker filters them with the same acceptance rule.

// File: rtl/ptr_add_pkg.sv
package ptr_add_pkg;

  typedef enum logic [1:0] {
    OP_PAIR  = 2'd0,
    OP_SPUPD = 2'd1,
    OP_SPLD  = 2'd2,
    OP_NONE  = 2'd3
  } padd_op_e;

  localparam int FLAG_W = 8;
  localparam int FB_Z   = 7;
  localparam int FB_N   = 6;
  localparam int FB_H   = 5;
  localparam int FB_C   = 4;

endpackage

// File: rtl/ptr_add_ctrl.sv
module ptr_add_ctrl
  import ptr_add_pkg::*;
#(
  parameter int LAT_PAIR  = 8,
  parameter int LAT_SPUPD = 16,
  parameter int LAT_SPLD  = 12
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  padd_op_e op,
  output logic     accept,
  output logic     finish
);

  localparam int LAT_MAX = (LAT_PAIR > LAT_SPUPD)
                           ? ((LAT_PAIR > LAT_SPLD) ? LAT_PAIR : LAT_SPLD)
                           : ((LAT_SPUPD > LAT_SPLD) ? LAT_SPUPD : LAT_SPLD);
  localparam int CNT_W = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1;

  localparam logic [CNT_W-1:0] LD_PAIR  = CNT_W'(LAT_PAIR - 1);
  localparam logic [CNT_W-1:0] LD_SPUPD = CNT_W'(LAT_SPUPD - 1);
  localparam logic [CNT_W-1:0] LD_SPLD  = CNT_W'(LAT_SPLD - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    case (op)
      OP_SPUPD: load_val = LD_SPUPD;
      OP_SPLD:  load_val = LD_SPLD;
      default:  load_val = LD_PAIR;
    endcase
  end

  assign accept = start && !busy && (op != OP_NONE);
  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= load_val;
    end else if (finish) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt  <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/ptr_add_math.sv
module ptr_add_math
  import ptr_add_pkg::*;
#(
  parameter int W  = 16,
  parameter int OW = 8
) (
  input  padd_op_e          op,
  input  logic [W-1:0]      base,
  input  logic [W-1:0]      addend,
  input  logic [OW-1:0]     disp,
  input  logic              z_keep,
  output logic [W-1:0]      sum,
  output logic [FLAG_W-1:0] flags,
  output logic              to_sp
);

  localparam int PAIR_HB = W - 4;

  logic [W:0]   pair_full;
  logic [W-1:0] pair_x;
  logic [W-1:0] ext;
  logic [W-1:0] off_sum;
  logic [W-1:0] off_x;

  assign pair_full = {1'b0, base} + {1'b0, addend};
  assign pair_x    = base ^ addend ^ pair_full[W-1:0];

  assign ext     = {{(W-OW){disp[OW-1]}}, disp};
  assign off_sum = base + ext;
  assign off_x   = base ^ ext ^ off_sum;

  always_comb begin
    flags = '0;
    if (op == OP_PAIR) begin
      sum         = pair_full[W-1:0];
      flags[FB_Z] = z_keep;
      flags[FB_H] = pair_x[PAIR_HB];
      flags[FB_C] = pair_full[W];
      to_sp       = 1'b0;
    end else begin
      sum         = off_sum;
      flags[FB_H] = off_x[4];
      flags[FB_C] = off_x[OW];
      to_sp       = (op == OP_SPUPD);
    end
  end

endmodule

// File: rtl/ptr_add_unit.sv
module ptr_add_unit
  import ptr_add_pkg::*;
#(
  parameter int W         = 16,
  parameter int OW        = 8,
  parameter int LAT_PAIR  = 8,
  parameter int LAT_SPUPD = 16,
  parameter int LAT_SPLD  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [W-1:0]  base,
  input  logic [W-1:0]  addend,
  input  logic [OW-1:0] disp,
  input  logic          z_in,
  output logic [W-1:0]  result,
  output logic          dest_sp,
  output logic [7:0]    flags_out,
  output logic          done
);

  padd_op_e          op_in;
  padd_op_e          op_q;
  logic [W-1:0]      base_q;
  logic [W-1:0]      addend_q;
  logic [OW-1:0]     disp_q;
  logic              z_q;
  logic              accept;
  logic              finish;
  logic [W-1:0]      sum;
  logic [FLAG_W-1:0] flg;
  logic              to_sp;

  assign op_in = padd_op_e'(op);

  ptr_add_ctrl #(
    .LAT_PAIR (LAT_PAIR),
    .LAT_SPUPD(LAT_SPUPD),
    .LAT_SPLD (LAT_SPLD)
  ) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .op    (op_in),
    .accept(accept),
    .finish(finish)
  );

  ptr_add_math #(
    .W (W),
    .OW(OW)
  ) math_i (
    .op    (op_q),
    .base  (base_q),
    .addend(addend_q),
    .disp  (disp_q),
    .z_keep(z_q),
    .sum   (sum),
    .flags (flg),
    .to_sp (to_sp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_PAIR;
      base_q   <= '0;
      addend_q <= '0;
      disp_q   <= '0;
      z_q      <= 1'b0;
    end else if (accept) begin
      op_q     <= op_in;
      base_q   <= base;
      addend_q <= addend;
      disp_q   <= disp;
      z_q      <= z_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      dest_sp   <= 1'b0;
      flags_out <= '0;
      done      <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        result    <= sum;
        dest_sp   <= to_sp;
        flags_out <= flg;
      end
    end
  end

endmodule

// File: rtl/ptr_add_chk.sv
module ptr_add_chk #(
  parameter int W         = 16,
  parameter int LAT_PAIR  = 8,
  parameter int LAT_SPUPD = 16,
  parameter int LAT_SPLD  = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] result,
  input logic         dest_sp,
  input logic [7:0]   flags_out,
  input logic         done
);

  localparam int LAT_MAX = (LAT_PAIR > LAT_SPUPD)
                           ? ((LAT_PAIR > LAT_SPLD) ? LAT_PAIR : LAT_SPLD)
                           : ((LAT_SPUPD > LAT_SPLD) ? LAT_SPUPD : LAT_SPLD);
  localparam int CW = $clog2(LAT_MAX + 1) + 1;

  logic          pend;
  logic [CW-1:0] cyc;
  logic [CW-1:0] exp_lat;
  logic          take;

  assign take = start && (op != 2'd3) && (!pend || done);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      cyc     <= '0;
      exp_lat <= '0;
    end else if (take) begin
      pend    <= 1'b1;
      cyc     <= '0;
      exp_lat <= (op == 2'd1) ? CW'(LAT_SPUPD) :
                 (op == 2'd2) ? CW'(LAT_SPLD) : CW'(LAT_PAIR);
    end else begin
      if (done) pend <= 1'b0;
      else if (pend) cyc <= cyc + 1'b1;
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (pend && (cyc == exp_lat)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(result) && $stable(flags_out) && $stable(dest_sp)));

  // R9
  low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
    flags_out[3:0] == 4'h0);

  // R5
  sp_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (done && dest_sp) |-> (flags_out[7:6] == 2'b00));

  // R2
  sub_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !flags_out[6]);

  // R10
  reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (op == 2'd3) && !pend) |=> !done);

endmodule

bind ptr_add_unit ptr_add_chk #(
  .W        (W),
  .LAT_PAIR (LAT_PAIR),
  .LAT_SPUPD(LAT_SPUPD),
  .LAT_SPLD (LAT_SPLD)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .op       (op),
  .result   (result),
  .dest_sp  (dest_sp),
  .flags_out(flags_out),
  .done     (done)
);

// File: tb/ptr_add_unit_tb.sv
module ptr_add_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [15:0] base = '0;
  logic [15:0] addend = '0;
  logic [7:0]  disp = '0;
  logic        z_in = 1'b0;
  logic [15:0] result;
  logic        dest_sp;
  logic [7:0]  flags_out;
  logic        done;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string cur_tag = "R11";

  always #10 clk = ~clk;

  ptr_add_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .base(base),
    .addend(addend), .disp(disp), .z_in(z_in), .result(result),
    .dest_sp(dest_sp), .flags_out(flags_out), .done(done)
  );

  // behavioural reference model
  bit        m_busy;
  int        m_left;
  int        m_op, m_a, m_b, m_d, m_z;
  int        last_op;
  bit [15:0] e_res;
  bit [7:0]  e_flg;
  bit        e_dsp;
  bit        e_done;

  function automatic int lat_of(int o);
    if (o == 1) return 16;
    if (o == 2) return 12;
    return 8;
  endfunction

  task automatic ref_calc(input int o, a, b, d, z,
                          output bit [15:0] r, output bit [7:0] f, output bit s);
    int sum, hc, cc, sd;
    if (o == 0) begin
      sum = a + b;
      hc  = ((a & 'hFFF) + (b & 'hFFF)) > 'hFFF;
      cc  = sum > 'hFFFF;
      r   = sum[15:0];
      f   = 8'((z << 7) | (hc << 5) | (cc << 4));
      s   = 1'b0;
    end else begin
      sd  = (d >= 128) ? d - 256 : d;
      sum = a + sd;
      hc  = ((a & 'hF) + (d & 'hF)) > 'hF;
      cc  = ((a & 'hFF) + (d & 'hFF)) > 'hFF;
      r   = sum[15:0];
      f   = 8'((hc << 5) | (cc << 4));
      s   = (o == 1);
    end
  endtask

  always @(posedge clk) begin
    bit was_busy;
    cycles++;
    if (rst) begin
      m_busy = 0; m_left = 0; e_res = '0; e_flg = '0; e_dsp = 0; e_done = 0;
    end else begin
      was_busy = m_busy;
      e_done = 0;
      if (m_busy) begin
        if (m_left == 0) begin
          ref_calc(m_op, m_a, m_b, m_d, m_z, e_res, e_flg, e_dsp);
          e_done  = 1;
          m_busy  = 0;
          last_op = m_op;
        end else begin
          m_left--;
        end
      end
      if (start && !was_busy && op != 2'd3) begin
        m_busy = 1;
        m_op = int'(op); m_a = int'(base); m_b = int'(addend);
        m_d = int'(disp); m_z = int'(z_in);
        m_left = lat_of(m_op) - 1;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    string tr, tf;
    vectors++;
    tr = rst ? "R11" : (last_op == 0 ? "R1" : "R3");
    tf = rst ? "R11" : (last_op == 0 ? "R2" : "R5");
    if (result !== e_res) begin
      miscompares++;
      $display("FAIL %s/%s result got %h expected %h", tr, cur_tag, result, e_res);
    end
    if (flags_out !== e_flg) begin
      miscompares++;
      $display("FAIL %s/%s flags got %h expected %h", tf, cur_tag, flags_out, e_flg);
    end
    if (flags_out[3:0] !== 4'h0) begin
      miscompares++;
      $display("FAIL R9 flag low nibble got %h expected 0", flags_out[3:0]);
    end
    if (dest_sp !== e_dsp) begin
      miscompares++;
      $display("FAIL R4/%s dest_sp got %b expected %b", cur_tag, dest_sp, e_dsp);
    end
    if (done !== e_done) begin
      miscompares++;
      $display("FAIL R6/%s done got %b expected %b", cur_tag, done, e_done);
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog expired at cycle %0d expected under 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic run_op(input logic [1:0] o, input logic [15:0] a, b,
                        input logic [7:0] d, input logic z, input string tag);
    @(negedge clk);
    cur_tag = tag;
    op = o; base = a; addend = b; disp = d; z_in = z; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
  endtask

  task automatic chk_now(input string tag, input logic [15:0] r,
                         input logic [7:0] f, input logic s);
    vectors++;
    if (result !== r || flags_out !== f || dest_sp !== s) begin
      miscompares++;
      $display("FAIL %s got %h/%h/%b expected %h/%h/%b",
               tag, result, flags_out, dest_sp, r, f, s);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 R2: wrap, carries from bits 11 and 15, zero flag kept
    run_op(2'd0, 16'hFFFF, 16'h0001, 8'h00, 1'b1, "R1");
    chk_now("R2 pair wrap", 16'h0000, 8'hB0, 1'b0);
    run_op(2'd0, 16'h0FFF, 16'h0001, 8'h00, 1'b0, "R2");
    chk_now("R2 bit11 carry", 16'h1000, 8'h20, 1'b0);
    run_op(2'd0, 16'h8000, 16'h8000, 8'h00, 1'b0, "R2");
    chk_now("R2 bit15 carry", 16'h0000, 8'h10, 1'b0);

    // R3 R4 R5: stack update and load with signed displacement
    run_op(2'd1, 16'h00FF, 16'h1234, 8'h01, 1'b1, "R5");
    chk_now("R5 low-byte carries", 16'h0100, 8'h30, 1'b1);
    run_op(2'd1, 16'h0000, 16'h0000, 8'hFF, 1'b1, "R3");
    chk_now("R3 minus one", 16'hFFFF, 8'h00, 1'b1);
    run_op(2'd2, 16'h0005, 16'h0000, 8'h80, 1'b0, "R3");
    chk_now("R3 most negative", 16'hFF85, 8'h00, 1'b0);
    run_op(2'd2, 16'hFFF8, 16'h0000, 8'h08, 1'b1, "R4");
    chk_now("R4 load form", 16'h0000, 8'h30, 1'b0);

    // R10: reserved code is ignored
    run_op(2'd3, 16'h1111, 16'h2222, 8'h33, 1'b1, "R10");
    repeat (20) @(negedge clk);
    chk_now("R10 reserved ignored", 16'h0000, 8'h30, 1'b0);

    // R7: start during busy is ignored
    @(negedge clk);
    cur_tag = "R7";
    op = 2'd0; base = 16'h1234; addend = 16'h0101; start = 1'b1; z_in = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    op = 2'd1; base = 16'hAAAA; disp = 8'h7F; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    chk_now("R7 busy start ignored", 16'h1335, 8'h00, 1'b0);

    // R8: outputs hold while inputs move without start
    cur_tag = "R8";
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      base = 16'($urandom); addend = 16'($urandom); disp = 8'($urandom);
    end
    chk_now("R8 hold", 16'h1335, 8'h00, 1'b0);

    // mixed stimulus: random starts, codes and corner-biased operands (R6 R7)
    cur_tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      @(negedge clk);
      sel = $urandom % 4;
      start  = ($urandom % 3) == 0;
      op     = 2'($urandom);
      base   = (sel == 0) ? 16'hFFFF : (sel == 1) ? 16'h0000 : 16'($urandom);
      addend = (sel == 2) ? 16'h0001 : 16'($urandom);
      disp   = (sel == 3) ? 8'h80 : 8'($urandom);
      z_in   = 1'($urandom);
    end
    @(negedge clk);
    start = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);

    // R11: reset clears the outputs
    cur_tag = "R11";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_now("R11 reset state", 16'h0000, 8'h00, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule